// File: doc/BRIEF.md
# Operand Stack Cache with Background Spill and Refill

This block holds the topmost entries of a stack processor's operand stack in a small register file. The file is run as a ring: one pointer marks the oldest resident entry and an occupancy count fixes where the top sits. The execute datapath sees the two topmost entries at all times. In any cycle it may push a value, pop the top, or do both at once, which overwrites the top in place.

A transfer engine works on the bottom end of the ring while the datapath works on the top end. When occupancy rises above a high watermark, the engine copies the oldest resident entry out to a backing memory. When occupancy falls below a low watermark and the memory still holds saved entries, it reads the most recently saved entry back in below the oldest resident one. Backing memory is used as an upward-growing array that starts at address 0. It is reached through a single request/acknowledge port. A request stays raised until it is acknowledged, and the acknowledge completes the transfer in that same cycle.

The core is held off only in the few cases where the ring cannot serve it. The `stall` output is combinational in the current inputs. It tells the core that its operation this cycle was refused and must be repeated. The ring depth must be a power of two.

Top module: `stack_cache`

## Requirements
- R1: After synchronous reset, `count` is 0, `mem_req` is 0, and with no operation requested `stall` is 0.
- R2: An accepted push places `push_data` at the top: `tos` shows the newest entry and `nos` the one beneath it, whenever that many entries are resident.
- R3: An accepted push together with a pop replaces the top entry with `push_data` and leaves `count` unchanged, unless a transfer completes in the same cycle.
- R4: `count` equals the number of resident entries and never exceeds DEPTH. An accepted lone push adds 1, an accepted lone pop subtracts 1, a refill adds 1 and a spill subtracts 1.
- R5: When no transfer is pending and `count` > HI_WM, the next cycle raises `mem_req` with `mem_we`=1. `mem_addr` is then the number of entries already saved, and `mem_wdata` is the oldest resident entry.
- R6: When no transfer is pending, `count` < LO_WM and at least one entry is saved, the next cycle raises `mem_req` with `mem_we`=0 and `mem_addr` equal to the saved count minus 1. On acknowledge, `mem_rdata` becomes the new oldest resident entry.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R8: `stall` is raised for a pop (alone or with a push) when `count` is 0, or when `count` is 1 and a spill is pending. It is raised for a lone push when `count` plus a pending refill reaches DEPTH. A stalled operation changes nothing.
- R9: A transfer that completes in the same cycle as an accepted push or pop takes effect together with it, and `count` reflects both.
- R10: No spill is started once 2^MEM_AW entries are saved. Pushes then fill the ring to DEPTH and stall after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Push request from the datapath |
| pop | input | 1 | Pop request from the datapath |
| push_data | input | DW | Value to push |
| stall | output | 1 | This cycle's operation refused |
| tos | output | DW | Top entry |
| nos | output | DW | Entry below the top |
| count | output | clog2(DEPTH+1) | Resident entries |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | 1 = spill write, 0 = refill read |
| mem_addr | output | MEM_AW | Backing memory word address |
| mem_wdata | output | DW | Spilled value |
| mem_rdata | input | DW | Refill value, valid with mem_ack |
| mem_ack | input | 1 | Completes the pending request |

## Verification
The bench builds the block with an 8-entry ring, watermarks 5 and 2, 16-bit words and a 16-word backing memory. With these values a burst of two dozen pushes fills the backing store to its limit and then fills the ring, so the spill cap and the full-ring push stall are both reached in a short run. The low depth also lets a withheld acknowledge leave a spill pending while pops bring the ring down to its last entry. It likewise lets a refill stay pending while pushes bring the ring to one short of full. Both of these are the stall corners.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SPILL = 2'd1,
    XF_FILL  = 2'd2
  } xfer_e;
endpackage

// File: rtl/sc_regfile.sv
// Ring storage: two compute read ports, a spill read port,
// one compute write port and one refill write port.
module sc_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          cw_en,
  input  logic [IW-1:0] cw_idx,
  input  logic [DW-1:0] cw_data,
  input  logic          fw_en,
  input  logic [IW-1:0] fw_idx,
  input  logic [DW-1:0] fw_data,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic [IW-1:0] rs_idx,
  output logic [DW-1:0] rs_data
);
  logic [DW-1:0] mem [DEPTH];

  // The two write indices never collide: the controller keeps one slot free.
  always_ff @(posedge clk) begin
    if (cw_en) mem[cw_idx] <= cw_data;
    if (fw_en) mem[fw_idx] <= fw_data;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
  assign rs_data = mem[rs_idx];
endmodule

// File: rtl/sc_ctrl.sv
// Ring pointers, occupancy and acceptance of compute operations.
module sc_ctrl #(
  parameter int DEPTH = 64,
  parameter int IW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          spill_busy,
  input  logic          fill_busy,
  input  logic          spill_done,
  input  logic          fill_done,
  output logic          stall,
  output logic          cw_en,
  output logic [IW-1:0] cw_idx,
  output logic [IW-1:0] top_idx,
  output logic [IW-1:0] nos_idx,
  output logic [IW-1:0] bot_idx,
  output logic [IW-1:0] fw_idx,
  output logic [CW-1:0] count
);
  logic [IW-1:0] bot_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   need;
  logic          pop_ok, room, pop_acc, push_acc;

  always_comb begin
    pop_ok   = (cnt_q != '0) && !((cnt_q == CW'(1)) && spill_busy);
    need     = {1'b0, cnt_q} + (CW+1)'(fill_busy);
    room     = need < (CW+1)'(DEPTH);
    pop_acc  = pop & pop_ok;
    push_acc = push & (pop ? pop_ok : room);
    stall    = pop ? !pop_ok : (push & !room);
    top_idx  = bot_q + cnt_q[IW-1:0] - IW'(1);
    nos_idx  = top_idx - IW'(1);
    cw_en    = push_acc;
    cw_idx   = pop ? top_idx : (bot_q + cnt_q[IW-1:0]);
    fw_idx   = bot_q - IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bot_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(push_acc && !pop) - CW'(pop_acc && !push)
                     + CW'(fill_done) - CW'(spill_done);
      bot_q <= bot_q + IW'(spill_done) - IW'(fill_done);
    end
  end

  assign bot_idx = bot_q;
  assign count   = cnt_q;
endmodule

// File: rtl/sc_xfer.sv
// Watermark-driven spill/refill engine and backing memory port.
module sc_xfer
  import sc_pkg::*;
#(
  parameter int DW  = 32,
  parameter int MAW = 16,
  parameter int CW  = 7,
  parameter int HI  = 56,
  parameter int LO  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  count,
  input  logic [DW-1:0]  spill_src,
  input  logic           mem_ack,
  output logic           spill_busy,
  output logic           fill_busy,
  output logic           spill_done,
  output logic           fill_done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata
);
  localparam int CAP = 1 << MAW;

  xfer_e        st;
  logic [MAW:0] saved;
  logic         want_spill, want_fill;

  always_comb begin
    spill_busy = (st == XF_SPILL);
    fill_busy  = (st == XF_FILL);
    spill_done = spill_busy & mem_ack;
    fill_done  = fill_busy & mem_ack;
    want_spill = (int'(count) > HI) && (int'(saved) < CAP);
    want_fill  = (int'(count) < LO) && (saved != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= XF_IDLE;
      saved     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (st)
        XF_IDLE: begin
          if (want_spill) begin
            st        <= XF_SPILL;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= saved[MAW-1:0];
            mem_wdata <= spill_src;
          end else if (want_fill) begin
            st       <= XF_FILL;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= saved[MAW-1:0] - MAW'(1);
          end
        end
        XF_SPILL: if (mem_ack) begin
          st      <= XF_IDLE;
          mem_req <= 1'b0;
          saved   <= saved + (MAW+1)'(1);
        end
        XF_FILL: if (mem_ack) begin
          st      <= XF_IDLE;
          mem_req <= 1'b0;
          saved   <= saved - (MAW+1)'(1);
        end
        default: st <= XF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_cache.sv
module stack_cache #(
  parameter int DW     = 32,
  parameter int DEPTH  = 64,
  parameter int HI_WM  = 56,
  parameter int LO_WM  = 8,
  parameter int MEM_AW = 16,
  parameter int IW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DW-1:0]     push_data,
  output logic              stall,
  output logic [DW-1:0]     tos,
  output logic [DW-1:0]     nos,
  output logic [CW-1:0]     count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack
);
  logic          spill_busy, fill_busy, spill_done, fill_done, cw_en;
  logic [IW-1:0] cw_idx, top_idx, nos_idx, bot_idx, fw_idx;
  logic [DW-1:0] spill_src;

  sc_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .spill_busy(spill_busy), .fill_busy(fill_busy),
    .spill_done(spill_done), .fill_done(fill_done),
    .stall(stall), .cw_en(cw_en), .cw_idx(cw_idx),
    .top_idx(top_idx), .nos_idx(nos_idx), .bot_idx(bot_idx),
    .fw_idx(fw_idx), .count(count)
  );

  sc_regfile #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_rf (
    .clk(clk),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(push_data),
    .fw_en(fill_done), .fw_idx(fw_idx), .fw_data(mem_rdata),
    .ra_idx(top_idx), .ra_data(tos),
    .rb_idx(nos_idx), .rb_data(nos),
    .rs_idx(bot_idx), .rs_data(spill_src)
  );

  sc_xfer #(.DW(DW), .MAW(MEM_AW), .CW(CW), .HI(HI_WM), .LO(LO_WM)) u_xfer (
    .clk(clk), .rst(rst), .count(count), .spill_src(spill_src),
    .mem_ack(mem_ack), .spill_busy(spill_busy), .fill_busy(fill_busy),
    .spill_done(spill_done), .fill_done(fill_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int HI    = 56,
  parameter int LO    = 8,
  parameter int MAW   = 16,
  parameter int CW    = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           push,
  input logic           pop,
  input logic           stall,
  input logic [CW-1:0]  count,
  input logic           mem_req,
  input logic           mem_we,
  input logic [MAW-1:0] mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           mem_ack
);
  localparam int CAP = 1 << MAW;
  int saved_q;

  always_ff @(posedge clk) begin
    if (rst) saved_q <= 0;
    else if (mem_req && mem_ack) saved_q <= mem_we ? saved_q + 1 : saved_q - 1;
  end

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0) && !mem_req);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                              && $stable(mem_wdata));

  a_r5_spill_high: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_we) |-> int'($past(count)) > HI);

  a_r6_fill_low: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && !mem_we) |-> (int'($past(count)) < LO) && (saved_q > 0));

  a_r10_spill_cap: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_we) |-> saved_q < CAP);

  a_r8_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0) |-> stall);

  a_r3_replace: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !stall && !(mem_req && mem_ack)) |=> count == $past(count));
endmodule

bind stack_cache sc_checker #(
  .DW(DW), .DEPTH(DEPTH), .HI(HI_WM), .LO(LO_WM), .MAW(MEM_AW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .stall(stall), .count(count),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_stack_cache.sv
module sim_stack_cache;
  localparam int DW = 16, DEPTH = 8, HI = 5, LO = 2, MAW = 4;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int CAP = 1 << MAW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, push, pop, mem_ack;
  logic [DW-1:0] push_data, mem_rdata, tos, nos, mem_wdata;
  logic stall, mem_req, mem_we;
  logic [CW-1:0] count;
  logic [MAW-1:0] mem_addr;

  logic [DW-1:0] bmem [CAP];
  assign mem_rdata = bmem[mem_addr];

  stack_cache #(.DW(DW), .DEPTH(DEPTH), .HI_WM(HI), .LO_WM(LO), .MEM_AW(MAW)) u0 (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_data(push_data),
    .stall(stall), .tos(tos), .nos(nos), .count(count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // Behavioural reference state
  logic [DW-1:0] q[$];
  int saved, maddr, ack_mode, nvec, nfail;
  bit busy, kspill, prev_conc, prev_repl, done;
  logic [DW-1:0] mdata;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] seq = 16'h0100;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic adv();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push = 1'b0; pop = 1'b0; mem_ack = 1'b0; push_data = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q.delete(); saved = 0; busy = 0; kspill = 0; prev_conc = 0; prev_repl = 0;
    #1;
    check(count == '0, "R1", "count after reset", count, 0);
    check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
    check(stall == 1'b0, "R1", "stall after reset", stall, 0);
  endtask

  task automatic step(bit pu, bit po);
    int n;
    bit pop_ok, room, es, acc_pop, acc_push, conc, repl;
    int nl, la;
    logic [DW-1:0] ld, d;
    @(negedge clk);
    d = seq; seq = seq + 16'h0013;
    push = pu; pop = po; push_data = d;
    case (ack_mode)
      0: mem_ack = mem_req;
      1: mem_ack = mem_req & lfsr[3];
      default: mem_ack = 1'b0;
    endcase
    adv();
    #1;
    n = q.size();
    pop_ok = (n != 0) && !(n == 1 && busy && kspill);
    room = (n + ((busy && !kspill) ? 1 : 0)) < DEPTH;
    es = po ? !pop_ok : (pu && !room);
    check(stall === es, "R8", "stall", stall, es);
    check(count === CW'(n), prev_conc ? "R9" : (prev_repl ? "R3" : "R4"), "count", count, n);
    if (n >= 1) check(tos === q[n-1], prev_repl ? "R3" : "R2", "tos", tos, q[n-1]);
    if (n >= 2) check(nos === q[n-2], "R2", "nos", nos, q[n-2]);
    if (busy) begin
      check(mem_req === 1'b1, "R7", "mem_req held", mem_req, 1);
      check(mem_we === kspill, kspill ? "R5" : "R6", "mem_we", mem_we, kspill);
      check(mem_addr === MAW'(maddr), kspill ? "R5" : "R6", "mem_addr", mem_addr, maddr);
      if (kspill) check(mem_wdata === mdata, "R5", "mem_wdata", mem_wdata, mdata);
    end else begin
      check(mem_req === 1'b0, (saved == CAP && n > HI) ? "R10" : "R7",
            "mem_req idle", mem_req, 0);
    end
    // reference update for the coming edge
    acc_pop = po && pop_ok;
    acc_push = pu && (po ? pop_ok : room);
    nl = 0; la = 0; ld = '0;
    if (!busy) begin
      if (n > HI && saved < CAP) begin nl = 1; la = saved; ld = q[0]; end
      else if (n < LO && saved > 0) begin nl = 2; la = saved - 1; end
    end
    conc = 0;
    if (busy && mem_ack) begin
      if (kspill) begin
        bmem[maddr] = mem_wdata;
        void'(q.pop_front());
        saved++;
      end else begin
        q.push_front(bmem[maddr]);
        saved--;
      end
      busy = 0;
      conc = acc_push || acc_pop;
    end
    repl = 0;
    if (acc_push && po) begin q[q.size()-1] = d; repl = !conc; end
    else if (acc_push) q.push_back(d);
    else if (acc_pop) void'(q.pop_back());
    if (nl != 0) begin busy = 1; kspill = (nl == 1); maddr = la; mdata = ld; end
    prev_conc = conc;
    prev_repl = repl;
  endtask

  initial begin
    nvec = 0; nfail = 0; done = 0; ack_mode = 0;
    for (int i = 0; i < CAP; i++) bmem[i] = '0;
    // A: basic push, pop, replace
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 1); step(0, 1);
    step(1, 1); step(1, 1);
    step(0, 0); step(0, 0);
    // B: fill backing store to its cap, then the ring; drain fully
    do_reset();
    for (int i = 0; i < 30; i++) step(1, 0);
    repeat (3) step(0, 0);
    for (int i = 0; i < 32; i++) step(0, 1);
    // C: spill pending while popping down to the last entry
    do_reset();
    ack_mode = 2;
    for (int i = 0; i < 6; i++) step(1, 0);
    for (int i = 0; i < 7; i++) step(0, 1);
    ack_mode = 0;
    repeat (6) step(0, 0);
    // D: refill pending while pushing up to one short of full
    do_reset();
    for (int i = 0; i < 10; i++) step(1, 0);
    ack_mode = 2;
    for (int i = 0; i < 6; i++) step(0, 1);
    for (int i = 0; i < 8; i++) step(1, 0);
    ack_mode = 0;
    repeat (4) step(0, 0);
    for (int i = 0; i < 14; i++) step(0, 1);
    // E: mixed traffic with varying acknowledge timing
    do_reset();
    for (int i = 0; i < 1200; i++) begin
      if (i % 60 == 0) ack_mode = (lfsr[1:0] == 2'b11) ? 2 : int'(lfsr[0]);
      step(lfsr[5] | (lfsr[6] & lfsr[7]), lfsr[9]);
    end
    ack_mode = 0;
    for (int i = 0; i < 40; i++) step(0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R7 watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule